// File: doc/BRIEF.md
# VIPT L1 Cache Lookup

This block is a set-associative level-one data cache. Its sets are selected by virtual address bits and its lines are tagged with physical page numbers. A request presents only the untranslated low twelve bits of its virtual address, so the set lookup can proceed while an external translation unit works on the upper bits. The following cycle the translation result arrives as a physical page number. That number is compared with the stored tag of every way of the selected set in parallel, and the data of the matching way is then picked out.

Read misses fetch a whole 64-byte line through a refill port. The victim way is chosen by a round-robin pointer kept for each set. Writes are write-through with no allocation: a write that hits merges its bytes into the cached word, and a write that misses changes nothing. A translation miss makes the request come back as a replay, with no effect on the cache. The block serves one request at a time.

Because set index plus line offset must fit inside the 4 KiB page offset, capacity is ways × 4 KiB. The default is 8 ways and 32 KiB. A parameter set that needs more than twelve index and offset bits stops elaboration.

Top module: `vipt_l1_lookup`

## Requirements
- R1: The set is `req_vofs[11:6]` and the 32-bit word within the line is `req_vofs[5:2]`. Bits 1:0 of `req_vofs` do not affect the result. Word k of a line occupies bits 32k+31:32k of the refill line.
- R2: A request accepted at a clock edge resolves in the following cycle. That cycle samples `xlat_ppn`, and exactly one of `resp_hit`, `resp_miss` or `resp_replay` is high in it. A read hit raises `rdata_valid` with the word in that same cycle.
- R3: A hit occurs only when a valid way of the set holds a tag equal to `xlat_ppn`. At most one way hits.
- R4: When `xlat_miss` is high in the resolve cycle, only `resp_replay` pulses. No hit, miss, data, refill or array change follows, for reads and writes alike.
- R5: A read miss raises `refill_req` from the next cycle until `refill_valid`. It carries `refill_addr = {ppn, set}` (26 bits), which stays stable throughout.
- R6: The cycle with `refill_valid` high writes the line and tag into the set's round-robin victim way, marks it valid and raises `rdata_valid` with the requested word of the incoming line. The pointer then advances modulo the way count, so the ninth distinct fill into a set evicts the first.
- R7: A write hit updates only the bytes of the addressed word whose `req_wbe` bit is set (bit b covers data bits 8b+7:8b) and returns no data. A write miss signals `resp_miss` but neither refills nor changes any line.
- R8: Reset clears every valid bit and round-robin pointer. After reset every lookup misses, whatever tags remain stored.
- R9: `req_ready` is high only when no request is in flight, so it is low during the resolve cycle and throughout a refill.
- R10: If neither `xlat_valid` nor `xlat_miss` is high in the resolve cycle, the block waits with all response outputs low and resolves in the first cycle that has one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = word write, 0 = read |
| req_vofs | input | 12 | Untranslated page-offset bits of the virtual address |
| req_wdata | input | 32 | Write data |
| req_wbe | input | 4 | Byte enables for a write |
| xlat_valid | input | 1 | Translation result valid in resolve cycle |
| xlat_miss | input | 1 | Translation failed; request must replay |
| xlat_ppn | input | 20 | Translated physical page number |
| resp_hit | output | 1 | Lookup hit |
| resp_miss | output | 1 | Lookup miss |
| resp_replay | output | 1 | Request dropped because translation missed |
| rdata_valid | output | 1 | Read word valid |
| rdata | output | 32 | Read word |
| refill_req | output | 1 | Line fetch pending |
| refill_addr | output | 26 | Physical line address of the pending fetch |
| refill_valid | input | 1 | Refill line present |
| refill_line | input | 512 | Full refill line |

## Verification
The bench sweeps every set, missing once and then hitting on a different word. A design that took the index from the wrong bits, or compared against a tag from the wrong cycle, would return words of the wrong line. It fills nine distinct pages into one set and checks that exactly the oldest one is gone. A victim choice that ignored the rotating pointer, or a pointer that stalled, would evict a live page instead. Byte-masked write hits, write misses, replayed reads and writes, and a late translation are each followed by readback. A design that allocated on write misses, let a replay touch the arrays or refill, or resolved before translation arrived would show a wrong word, a spurious refill or an early response. A mid-run reset followed by a lookup of a formerly cached page catches a design that keeps valid bits or trusts stale tags.

// File: rtl/vipt_l1_pkg.sv
package vipt_l1_pkg;
  localparam int unsigned PAGE_OFS_BITS = 12;
  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_FILL} lk_state_e;
endpackage

// File: rtl/vipt_l1_way.sv
// One way: valid bits, physical tags and line data for every set.
module vipt_l1_way #(
  parameter int unsigned SETS       = 64,
  parameter int unsigned TAG_W      = 20,
  parameter int unsigned LINE_W     = 512,
  parameter int unsigned WORD_W     = 32,
  localparam int unsigned SET_BITS  = $clog2(SETS),
  localparam int unsigned WORDS     = LINE_W / WORD_W,
  localparam int unsigned WIDX_BITS = $clog2(WORDS),
  localparam int unsigned WBYTES    = WORD_W / 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SET_BITS-1:0]  rd_set,
  input  logic [TAG_W-1:0]     cmp_ppn,
  output logic                 hit_o,
  output logic [LINE_W-1:0]    line_o,
  input  logic                 fill_en,
  input  logic [SET_BITS-1:0]  fill_set,
  input  logic [TAG_W-1:0]     fill_tag,
  input  logic [LINE_W-1:0]    fill_line,
  input  logic                 wr_en,
  input  logic [SET_BITS-1:0]  wr_set,
  input  logic [WIDX_BITS-1:0] wr_widx,
  input  logic [WBYTES-1:0]    wr_be,
  input  logic [WORD_W-1:0]    wr_data
);
  logic              valid_q [SETS];
  logic [TAG_W-1:0]  tag_q   [SETS];
  logic [LINE_W-1:0] data_q  [SETS];

  // Invalid entries never match, regardless of stale tag contents.
  assign hit_o  = valid_q[rd_set] && (tag_q[rd_set] == cmp_ppn);
  assign line_o = data_q[rd_set];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= 1'b0;
    end else if (fill_en) begin
      valid_q[fill_set] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_set]  <= fill_tag;
      data_q[fill_set] <= fill_line;
    end else if (wr_en) begin
      for (int b = 0; b < WBYTES; b++) begin
        if (wr_be[b])
          data_q[wr_set][int'(wr_widx)*WORD_W + b*8 +: 8] <= wr_data[b*8 +: 8];
      end
    end
  end

  // R6: a fill leaves the entry valid
  a_r6_fill_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> valid_q[$past(fill_set)]);
endmodule

// File: rtl/vipt_l1_victim.sv
// Per-set round-robin victim pointer.
module vipt_l1_victim #(
  parameter int unsigned SETS     = 64,
  parameter int unsigned WAYS     = 8,
  localparam int unsigned SET_BITS = $clog2(SETS),
  localparam int unsigned IDX_W    = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SET_BITS-1:0] set_i,
  input  logic                adv_i,
  output logic [WAYS-1:0]     victim_oh
);
  logic [IDX_W-1:0] rr_q [SETS];

  function automatic logic [IDX_W-1:0] rr_next(input logic [IDX_W-1:0] cur);
    return (int'(cur) == WAYS - 1) ? '0 : cur + 1'b1;
  endfunction

  always_comb begin
    victim_oh = '0;
    victim_oh[rr_q[set_i]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
    end else if (adv_i) begin
      rr_q[set_i] <= rr_next(rr_q[set_i]);
    end
  end

  if (WAYS > 1) begin : g_rr_chk
    // R6: every fill moves the pointer of its set
    a_r6_pointer_moves: assert property (@(posedge clk) disable iff (!rst_n)
      adv_i |=> (rr_q[$past(set_i)] != $past(rr_q[set_i])));
  end
endmodule

// File: rtl/vipt_l1_hit_mux.sv
// One-hot selection of the hitting way's line.
module vipt_l1_hit_mux #(
  parameter int unsigned WAYS   = 8,
  parameter int unsigned LINE_W = 512
) (
  input  logic [WAYS-1:0]   sel_oh,
  input  logic [LINE_W-1:0] lines_i [WAYS],
  output logic [LINE_W-1:0] line_o
);
  always_comb begin
    line_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (sel_oh[w]) line_o = line_o | lines_i[w];
    end
  end
endmodule

// File: rtl/vipt_l1_lookup.sv
module vipt_l1_lookup
  import vipt_l1_pkg::*;
#(
  parameter int unsigned WAYS       = 8,
  parameter int unsigned SETS       = 64,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned WORD_BYTES = 4,
  parameter int unsigned PPN_W      = 20,
  localparam int unsigned LINE_W    = LINE_BYTES * 8,
  localparam int unsigned WORD_W    = WORD_BYTES * 8,
  localparam int unsigned OFS_BITS  = $clog2(LINE_BYTES),
  localparam int unsigned SET_BITS  = $clog2(SETS),
  localparam int unsigned WSEL_BITS = $clog2(WORD_BYTES),
  localparam int unsigned WIDX_BITS = OFS_BITS - WSEL_BITS,
  localparam int unsigned VOFS_W    = PAGE_OFS_BITS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_write,
  input  logic [VOFS_W-1:0]         req_vofs,
  input  logic [WORD_W-1:0]         req_wdata,
  input  logic [WORD_BYTES-1:0]     req_wbe,
  input  logic                      xlat_valid,
  input  logic                      xlat_miss,
  input  logic [PPN_W-1:0]          xlat_ppn,
  output logic                      resp_hit,
  output logic                      resp_miss,
  output logic                      resp_replay,
  output logic                      rdata_valid,
  output logic [WORD_W-1:0]         rdata,
  output logic                      refill_req,
  output logic [PPN_W+SET_BITS-1:0] refill_addr,
  input  logic                      refill_valid,
  input  logic [LINE_W-1:0]         refill_line
);
  // Index and offset must stay inside the untranslated page offset.
  if (SET_BITS + OFS_BITS > PAGE_OFS_BITS) begin : g_index_too_wide
    $error("set index plus line offset exceed the page offset bits");
  end

  function automatic logic [SET_BITS-1:0] set_of(input logic [VOFS_W-1:0] v);
    return v[OFS_BITS +: SET_BITS];
  endfunction

  function automatic logic [WIDX_BITS-1:0] word_of(input logic [VOFS_W-1:0] v);
    return v[WSEL_BITS +: WIDX_BITS];
  endfunction

  function automatic logic [WORD_W-1:0] pick_word(input logic [LINE_W-1:0] line,
                                                  input logic [WIDX_BITS-1:0] idx);
    return line[int'(idx)*WORD_W +: WORD_W];
  endfunction

  lk_state_e               state_q;
  logic                    q_write;
  logic [SET_BITS-1:0]     q_set;
  logic [WIDX_BITS-1:0]    q_word;
  logic [WORD_W-1:0]       q_wdata;
  logic [WORD_BYTES-1:0]   q_be;
  logic [PPN_W-1:0]        q_ppn;

  // Named internal events
  logic                    accept;
  logic                    lookup_ok;
  logic                    any_hit;
  logic                    wr_en;
  logic                    go_fill;
  logic                    fill_en;
  logic [WAYS-1:0]         hit_vec;
  logic [WAYS-1:0]         victim_oh;
  logic [LINE_W-1:0]       way_lines [WAYS];
  logic [LINE_W-1:0]       hit_line;
  logic                    unused_vofs;

  assign unused_vofs = ^req_vofs;

  assign req_ready   = (state_q == ST_IDLE);
  assign accept      = req_valid && req_ready;
  assign resp_replay = (state_q == ST_LOOK) && xlat_miss;
  assign lookup_ok   = (state_q == ST_LOOK) && xlat_valid && !xlat_miss;
  assign any_hit     = |hit_vec;
  assign resp_hit    = lookup_ok && any_hit;
  assign resp_miss   = lookup_ok && !any_hit;
  assign wr_en       = resp_hit && q_write;
  assign go_fill     = resp_miss && !q_write;
  assign refill_req  = (state_q == ST_FILL);
  assign refill_addr = {q_ppn, q_set};
  assign fill_en     = refill_req && refill_valid;
  assign rdata_valid = (resp_hit && !q_write) || fill_en;
  assign rdata       = fill_en ? pick_word(refill_line, q_word) : pick_word(hit_line, q_word);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    vipt_l1_way #(
      .SETS(SETS), .TAG_W(PPN_W), .LINE_W(LINE_W), .WORD_W(WORD_W)
    ) u_way (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_set    (q_set),
      .cmp_ppn   (xlat_ppn),
      .hit_o     (hit_vec[w]),
      .line_o    (way_lines[w]),
      .fill_en   (fill_en && victim_oh[w]),
      .fill_set  (q_set),
      .fill_tag  (q_ppn),
      .fill_line (refill_line),
      .wr_en     (wr_en && hit_vec[w]),
      .wr_set    (q_set),
      .wr_widx   (q_word),
      .wr_be     (q_be),
      .wr_data   (q_wdata)
    );
  end

  vipt_l1_victim #(.SETS(SETS), .WAYS(WAYS)) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (q_set),
    .adv_i     (fill_en),
    .victim_oh (victim_oh)
  );

  vipt_l1_hit_mux #(.WAYS(WAYS), .LINE_W(LINE_W)) u_mux (
    .sel_oh  (hit_vec),
    .lines_i (way_lines),
    .line_o  (hit_line)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      q_write <= 1'b0;
      q_set   <= '0;
      q_word  <= '0;
      q_wdata <= '0;
      q_be    <= '0;
      q_ppn   <= '0;
    end else begin
      if (accept) begin
        q_write <= req_write;
        q_set   <= set_of(req_vofs);
        q_word  <= word_of(req_vofs);
        q_wdata <= req_wdata;
        q_be    <= req_wbe;
      end
      if (lookup_ok) q_ppn <= xlat_ppn;
      unique case (state_q)
        ST_IDLE: if (accept) state_q <= ST_LOOK;
        ST_LOOK: begin
          if (resp_replay)  state_q <= ST_IDLE;
          else if (go_fill) state_q <= ST_FILL;
          else if (lookup_ok) state_q <= ST_IDLE;
        end
        ST_FILL: if (refill_valid) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R3: no two ways claim the same physical line
  a_r3_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOOK) |-> $onehot0(hit_vec));
  // R4: a replay carries no other outcome and frees the block
  a_r4_replay_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    resp_replay |-> (!resp_hit && !resp_miss && !rdata_valid));
  a_r4_replay_frees: assert property (@(posedge clk) disable iff (!rst_n)
    resp_replay |=> (req_ready && !refill_req));
  // R5: the fetch request holds its address until the line arrives
  a_r5_refill_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_req && !refill_valid) |=> (refill_req && $stable(refill_addr)));
  // R9: nothing is accepted while a line is being fetched
  a_r9_fill_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    refill_req |-> !req_ready);
  // R2: a resolve cycle has a single outcome
  a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({resp_hit, resp_miss, resp_replay}) <= 1);
endmodule

// File: tb/vipt_l1_lookup_tb_top.sv
`timescale 1ns/100ps
module vipt_l1_lookup_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [11:0]  req_vofs = '0;
  logic [31:0]  req_wdata = '0;
  logic [3:0]   req_wbe = '0;
  logic         xlat_valid = 1'b0, xlat_miss = 1'b0;
  logic [19:0]  xlat_ppn = '0;
  logic         resp_hit, resp_miss, resp_replay, rdata_valid;
  logic [31:0]  rdata;
  logic         refill_req;
  logic [25:0]  refill_addr;
  logic         refill_valid = 1'b0;
  logic [511:0] refill_line = '0;

  always #2.5 clk = ~clk;

  vipt_l1_lookup dut_i (.*);

  int n_chk = 0, n_bad = 0;
  bit o_hit, o_miss, o_replay, o_rdv, o_filled, o_frv;
  logic [31:0] o_rdata, o_frdata;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input logic [19:0] p, input int s, input int w);
    return ({12'h0, p} << 12) ^ (32'(s) << 4) ^ 32'(w) ^ 32'hA500_0000;
  endfunction

  function automatic logic [511:0] make_line(input logic [19:0] p, input int s);
    logic [511:0] l;
    for (int w = 0; w < 16; w++) l[w*32 +: 32] = pat(p, s, w);
    return l;
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                        input logic [3:0] be);
    logic [31:0] r = o;
    for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = n[b*8 +: 8];
    return r;
  endfunction

  // xmode: 0 translation valid, 1 translation miss, 2 one idle cycle then valid
  task automatic access(input bit wr, input int s, input int w, input logic [19:0] p,
                        input logic [31:0] wd, input logic [3:0] be, input int xmode,
                        input int fdelay);
    @(negedge clk);
    check("R9 ready when idle", req_ready, 1);
    req_valid = 1'b1; req_write = wr;
    req_vofs = {6'(s), 4'(w), 2'(s)};
    req_wdata = wd; req_wbe = be;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 ready low in resolve", req_ready, 0);
    if (xmode == 2) begin
      #1 check("R10 waiting outputs", {resp_hit, resp_miss, resp_replay, rdata_valid}, 0);
      @(negedge clk);
    end
    xlat_valid = (xmode != 1); xlat_miss = (xmode == 1); xlat_ppn = p;
    #1;
    o_hit = resp_hit; o_miss = resp_miss; o_replay = resp_replay;
    o_rdv = rdata_valid; o_rdata = rdata;
    @(negedge clk);
    xlat_valid = 1'b0; xlat_miss = 1'b0;
    #1;
    o_filled = 1'b0; o_frv = 1'b0; o_frdata = '0;
    if (refill_req) begin
      check("R5 refill address", refill_addr, {p, 6'(s)});
      check("R9 ready low in refill", req_ready, 0);
      for (int i = 0; i < fdelay; i++) begin
        @(negedge clk); #1;
        check("R5 refill held", {refill_req, refill_addr}, {1'b1, p, 6'(s)});
      end
      refill_valid = 1'b1; refill_line = make_line(p, s);
      #0.5;
      o_filled = 1'b1; o_frv = rdata_valid; o_frdata = rdata;
      @(negedge clk);
      refill_valid = 1'b0;
    end
  endtask

  task automatic read_hit(input int s, input int w, input logic [19:0] p,
                          input logic [31:0] exp, input string tag);
    access(0, s, w, p, 0, 0, 0, 0);
    check({tag, " hit"}, {o_hit, o_miss, o_replay, o_rdv, o_filled}, 5'b10010);
    check({tag, " data"}, o_rdata, exp);
  endtask

  task automatic read_miss(input int s, input int w, input logic [19:0] p,
                           input int fdelay, input string tag);
    access(0, s, w, p, 0, 0, 0, fdelay);
    check({tag, " miss"}, {o_hit, o_miss, o_replay, o_rdv, o_filled}, 5'b01001);
    check({tag, " fill word"}, {o_frv, o_frdata}, {1'b1, pat(p, s, w)});
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R8 reset outputs",
          {req_ready, resp_hit, resp_miss, resp_replay, rdata_valid, refill_req}, 6'b100000);

    // R1 R2 R5 R6: every set, miss then hit on another word
    for (int s = 0; s < 64; s++) begin
      read_miss(s, s % 16, 20'h100 + 20'(s), s % 3, "R1 R5 R6 sweep");
      read_hit(s, (s + 5) % 16, 20'h100 + 20'(s), pat(20'h100 + 20'(s), s, (s + 5) % 16),
               "R1 R2 R3 sweep");
    end

    // R6: round robin in set 5 (way0 holds 0x105, pointer at 1)
    for (int k = 1; k <= 8; k++) read_miss(5, k, 20'h200 + 20'(k), 0, "R6 rr fill");
    read_miss(5, 0, 20'h105, 1, "R6 oldest evicted");
    read_hit(5, 2, 20'h202, pat(20'h202, 5, 2), "R6 second survives");
    read_hit(5, 9, 20'h208, pat(20'h208, 5, 9), "R6 newest survives");
    read_miss(5, 1, 20'h201, 0, "R6 second-oldest evicted");

    // R7: byte-masked write hit, write miss without allocation
    access(1, 10, 3, 20'h10A, 32'hAABB_CCDD, 4'b0101, 0, 0);
    check("R7 write hit", {o_hit, o_miss, o_rdv, o_filled}, 4'b1000);
    read_hit(10, 3, 20'h10A, merge(pat(20'h10A, 10, 3), 32'hAABB_CCDD, 4'b0101), "R7 merged");
    read_hit(10, 4, 20'h10A, pat(20'h10A, 10, 4), "R7 neighbour word");
    access(1, 10, 3, 20'h777, 32'h1234_5678, 4'b1111, 0, 0);
    check("R7 write miss no refill", {o_hit, o_miss, o_rdv, o_filled}, 4'b0100);
    read_hit(10, 3, 20'h10A, merge(pat(20'h10A, 10, 3), 32'hAABB_CCDD, 4'b0101),
             "R7 write miss left line");
    read_miss(10, 3, 20'h777, 0, "R7 no allocate");

    // R4: replays change nothing
    access(0, 20, 1, 20'h999, 0, 0, 1, 0);
    check("R4 read replay", {o_hit, o_miss, o_replay, o_rdv, o_filled}, 5'b00100);
    access(1, 20, 0, 20'h114, 32'hDEAD_BEEF, 4'b1111, 1, 0);
    check("R4 write replay", {o_hit, o_miss, o_replay, o_rdv, o_filled}, 5'b00100);
    read_hit(20, 0, 20'h114, pat(20'h114, 20, 0), "R4 line untouched");

    // R10: late translation
    access(0, 30, 7, 20'h11E, 0, 0, 2, 0);
    check("R10 late hit", {o_hit, o_miss, o_rdv, o_rdata}, {3'b101, pat(20'h11E, 30, 7)});

    // R8: reset mid-run invalidates everything
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    read_miss(0, 0, 20'h100, 0, "R8 stale tag after reset");
    read_miss(30, 7, 20'h11E, 0, "R8 second stale tag");
    read_hit(30, 8, 20'h11E, pat(20'h11E, 30, 8), "R8 refilled line");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule